// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block is a synthesizable model of a 1 Kbit serial EEPROM that answers Microwire commands. It has chip select, serial clock and data-in pins. The data-out pin is split into a data output and an output enable, so a pad or a bus model can build the tri-state.

A static strap picks the organization: 64 words of 16 bits or 128 bytes. The block decodes seven commands:

- read
- write
- single erase
- erase of the whole array
- fill of the whole array with one value
- write unlock
- write lock

Chip select, serial clock and data-in are oversampled in a faster system clock domain through synchronizers. Serial clock edges are found in that domain. Programming commands run a self-timed busy period of a parameterized number of system clocks. During that period the block reports busy or ready on data-out.

A host shifts in a start bit, an opcode, an address and, for writes, data. It then drops chip select to launch programming. It can raise chip select again to poll the ready/busy level until the cycle ends.

Top module: `uwire_eeprom`

## Requirements
- R1: A command is a 1 start bit, a 2-bit opcode and an address: 6 bits in 16-bit mode (`org_wide`=1) and 7 bits in 8-bit mode. Bits are sampled on rising `sk` edges, all fields are MSB first, and 0 bits before the start bit are skipped.
- R2: Opcode 10 reads. On the rising edge that takes the last address bit, `dout_oe` goes high with `dout`=0 (a dummy bit). Each following rising edge presents the next data bit, MSB first, for 16 or 8 bits. The next rising edge after that releases `dout_oe`.
- R3: Opcode 00 with top address bits 11 sets the write-enable latch, and 00 clears it. Reset clears it. While it is clear, write, erase, erase-all and write-all start no cycle and change nothing. Reads work in either state.
- R4: Opcode 01 followed by the data field writes the data. The target word or byte then holds exactly that data, whatever it held before. In 8-bit mode, byte address bit 0 = 1 selects bits 15:8 of 16-bit word address[6:1], and bit 0 = 0 selects bits 7:0.
- R5: Opcode 11 erases the addressed word or byte to all ones and leaves its neighbours untouched.
- R6: Opcode 00 with top address bits 10 sets every bit of the array to 1. Opcode 00 with top bits 01 and a data field loads every word or byte with that data. The rest of the address bits are don't-care.
- R7: A programming command takes effect on the falling edge of `cs` that follows a complete command. A command cut short by `cs` falling has no effect and starts no cycle.
- R8: A programming cycle stays busy for `PROG_CYCLES` system clocks after the falling `cs` is detected. Commands received while busy are ignored.
- R9: After a cycle starts, whenever `cs` is high, `dout_oe`=1 and `dout` shows 0 while busy and 1 when ready. A rising `sk` with `di`=1 releases `dout_oe` only when ready, and that bit counts as the next start bit.
- R10: After reset `dout_oe` is 0, every bit of the array reads as 1 and the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset (power-up) |
| org_wide | input | 1 | Organization strap: 1 selects 16-bit words, 0 selects bytes |
| sk | input | 1 | Serial clock pin |
| cs | input | 1 | Chip select pin, active high |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out value |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |

## Verification
Two functions can meet in one system cycle: the end of the busy timer and the serial-clock edge that carries a 1 on data-in. That edge either is dropped (while busy) or both clears the status output and starts a new command (once ready). The bench sends such edges during the busy window, including a whole write command, and clocks another one right after ready appears. It judges the outcome by the status level, by when `dout_oe` is released, and by a read-back showing that the write sent during busy left the array untouched. The exact cycle count from the falling chip select to the ready level is also checked against the busy length.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

   typedef enum logic [2:0] {
      PG_NONE,
      PG_WRITE,
      PG_ERASE,
      PG_ERAL,
      PG_WRAL
   } prog_e;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_HDR,
      FS_DATA,
      FS_READ,
      FS_ARMED,
      FS_WAIT
   } fstate_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EXT_WDS  = 2'b00;
   localparam logic [1:0] EXT_WRAL = 2'b01;
   localparam logic [1:0] EXT_ERAL = 2'b10;
   localparam logic [1:0] EXT_WEN  = 2'b11;

endpackage

// File: rtl/uwire_sync.sv
module uwire_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   logic [N-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uwire_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar k = 1; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/uwire_front.sv
module uwire_front
   import uwire_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8,
   parameter int AW_N     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic              sk_rise,
   input  logic              cs_s,
   input  logic              cs_fall,
   input  logic              di_s,
   input  logic              busy,
   input  logic [WIDE_W-1:0] rd_word,
   output logic [AW_N-1:0]   rd_addr,
   output logic              go,
   output prog_e             pg_cmd,
   output logic [AW_N-1:0]   pg_addr,
   output logic [WIDE_W-1:0] pg_data,
   output logic              wel,
   output logic              dout,
   output logic              dout_oe
);

   localparam int HDR_W = AW_N + 2;
   localparam int MAXB  = (HDR_W > WIDE_W) ? HDR_W : WIDE_W;
   localparam int CW    = $clog2(MAXB + 1);

   fstate_e           st;
   logic [CW-1:0]     cnt;
   logic [HDR_W-2:0]  hdr;
   logic [HDR_W-1:0]  hdr_nx;
   logic [WIDE_W-1:0] obuf;
   logic [WIDE_W-1:0] dbuf;
   logic              rd_oe;
   logic              rd_q;
   logic              stat_en;
   logic [1:0]        opc;
   logic [1:0]        ext;
   logic [AW_N-1:0]   fld;
   logic [CW-1:0]     hdr_last;
   logic [CW-1:0]     word_last;
   logic [WIDE_W-1:0] load_word;

   // field split depends on the organization strap
   always_comb begin
      hdr_nx = {hdr, di_s};
      if (wide) begin
         opc       = hdr_nx[AW_N:AW_N-1];
         fld       = {1'b0, hdr_nx[AW_N-2:0]};
         ext       = hdr_nx[AW_N-2:AW_N-3];
         hdr_last  = CW'(HDR_W - 2);
         word_last = CW'(WIDE_W - 1);
         load_word = rd_word;
      end else begin
         opc       = hdr_nx[AW_N+1:AW_N];
         fld       = hdr_nx[AW_N-1:0];
         ext       = hdr_nx[AW_N-1:AW_N-2];
         hdr_last  = CW'(HDR_W - 1);
         word_last = CW'(NARROW_W - 1);
         load_word = {rd_word[NARROW_W-1:0], {(WIDE_W-NARROW_W){1'b0}}};
      end
   end

   assign rd_addr = fld;
   assign pg_data = dbuf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FS_IDLE;
         cnt     <= '0;
         hdr     <= '0;
         obuf    <= '0;
         dbuf    <= '0;
         rd_oe   <= 1'b0;
         rd_q    <= 1'b0;
         wel     <= 1'b0;
         pg_cmd  <= PG_NONE;
         pg_addr <= '0;
      end else if (!cs_s) begin
         st    <= FS_IDLE;
         cnt   <= '0;
         rd_oe <= 1'b0;
      end else if (sk_rise) begin
         unique case (st)
            FS_IDLE: begin
               if (di_s && !busy) begin
                  st  <= FS_HDR;
                  cnt <= '0;
                  hdr <= '0;
               end
            end
            FS_HDR: begin
               hdr <= hdr_nx[HDR_W-2:0];
               cnt <= cnt + CW'(1);
               if (cnt == hdr_last) begin
                  cnt     <= '0;
                  pg_addr <= fld;
                  dbuf    <= '0;
                  unique case (opc)
                     OP_READ: begin
                        st    <= FS_READ;
                        rd_oe <= 1'b1;
                        rd_q  <= 1'b0;
                        obuf  <= load_word;
                     end
                     OP_WRITE: begin
                        st     <= FS_DATA;
                        pg_cmd <= PG_WRITE;
                     end
                     OP_ERASE: begin
                        st     <= FS_ARMED;
                        pg_cmd <= PG_ERASE;
                     end
                     default: begin
                        unique case (ext)
                           EXT_WEN: begin
                              wel <= 1'b1;
                              st  <= FS_WAIT;
                           end
                           EXT_WDS: begin
                              wel <= 1'b0;
                              st  <= FS_WAIT;
                           end
                           EXT_ERAL: begin
                              st     <= FS_ARMED;
                              pg_cmd <= PG_ERAL;
                           end
                           default: begin
                              st     <= FS_DATA;
                              pg_cmd <= PG_WRAL;
                           end
                        endcase
                     end
                  endcase
               end
            end
            FS_DATA: begin
               dbuf <= {dbuf[WIDE_W-2:0], di_s};
               cnt  <= cnt + CW'(1);
               if (cnt == word_last) st <= FS_ARMED;
            end
            FS_READ: begin
               if (cnt <= word_last) begin
                  rd_q <= obuf[WIDE_W-1];
                  obuf <= {obuf[WIDE_W-2:0], 1'b0};
                  cnt  <= cnt + CW'(1);
               end else begin
                  rd_oe <= 1'b0;
                  st    <= FS_WAIT;
               end
            end
            default: ;
         endcase
      end
   end

   // status output: armed by a launch, dropped by a 1 clocked in once ready
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                              stat_en <= 1'b0;
      else if (go)                                             stat_en <= 1'b1;
      else if (cs_s && sk_rise && di_s && !busy && st == FS_IDLE) stat_en <= 1'b0;
   end

   assign go      = cs_fall && (st == FS_ARMED) && wel && !busy;
   assign dout    = rd_oe ? rd_q : !busy;
   assign dout_oe = rd_oe || (stat_en && cs_s);

   a_r3_wel_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (wel != $past(wel)) |-> $past(sk_rise && cs_s));

   a_r2_read_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_oe && $past(rd_oe) && (rd_q != $past(rd_q))) |-> $past(sk_rise));

   a_r7_go_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !cs_s);

endmodule

// File: rtl/uwire_array.sv
module uwire_array
   import uwire_pkg::*;
#(
   parameter int WIDE_W      = 16,
   parameter int NARROW_W    = 8,
   parameter int WORDS       = 64,
   parameter int AW_N        = 7,
   parameter int PROG_CYCLES = 1250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic              go,
   input  prog_e             pg_cmd,
   input  logic [AW_N-1:0]   pg_addr,
   input  logic [WIDE_W-1:0] pg_data,
   input  logic [AW_N-1:0]   rd_addr,
   output logic [WIDE_W-1:0] rd_word,
   output logic              busy
);

   localparam int AW_W = AW_N - 1;
   localparam int HALF = NARROW_W;
   localparam int TW   = $clog2(PROG_CYCLES + 1);

   generate
      if (PROG_CYCLES < 1) begin : g_bad_prog
         $error("uwire_array needs PROG_CYCLES of at least one");
      end
   endgenerate

   logic [WORDS-1:0][WIDE_W-1:0] words;
   logic [AW_W-1:0]   widx;
   logic              hi_sel;
   logic              all_sel;
   logic              clr_sel;
   logic [HALF-1:0]   val_hi;
   logic [HALF-1:0]   val_lo;
   logic [AW_W-1:0]   ridx;
   logic [WIDE_W-1:0] rword;
   logic [TW-1:0]     tmr;

   always_comb begin
      widx    = wide ? pg_addr[AW_W-1:0] : pg_addr[AW_N-1:1];
      hi_sel  = pg_addr[0];
      all_sel = (pg_cmd == PG_ERAL) || (pg_cmd == PG_WRAL);
      clr_sel = (pg_cmd == PG_ERASE) || (pg_cmd == PG_ERAL);
      val_lo  = clr_sel ? '1 : pg_data[HALF-1:0];
      val_hi  = clr_sel ? '1 : (wide ? pg_data[WIDE_W-1:HALF] : pg_data[HALF-1:0]);
   end

   generate
      for (genvar i = 0; i < WORDS; i++) begin : g_word
         logic [WIDE_W-1:0] word_q;
         logic              hit;
         logic              en_hi;
         logic              en_lo;
         assign hit   = go && (all_sel || (widx == AW_W'(i)));
         assign en_hi = hit && (wide || all_sel || hi_sel);
         assign en_lo = hit && (wide || all_sel || !hi_sel);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '1;
            end else begin
               if (en_hi) word_q[WIDE_W-1:HALF] <= val_hi;
               if (en_lo) word_q[HALF-1:0]      <= val_lo;
            end
         end
         assign words[i] = word_q;
      end
   endgenerate

   always_comb begin
      ridx  = wide ? rd_addr[AW_W-1:0] : rd_addr[AW_N-1:1];
      rword = words[ridx];
      if (wide)            rd_word = rword;
      else if (rd_addr[0]) rd_word = {{(WIDE_W-HALF){1'b0}}, rword[WIDE_W-1:HALF]};
      else                 rd_word = {{(WIDE_W-HALF){1'b0}}, rword[HALF-1:0]};
   end

   // self-timed programming window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tmr  <= '0;
      end else if (go) begin
         busy <= 1'b1;
         tmr  <= TW'(PROG_CYCLES - 1);
      end else if (busy) begin
         if (tmr == '0) busy <= 1'b0;
         else           tmr  <= tmr - TW'(1);
      end
   end

   a_r8_busy_from_go: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go));

   a_r6_eral_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (go && pg_cmd == PG_ERAL) |=> (words[0] == '1 && words[WORDS-1] == '1));

   a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (go && pg_cmd == PG_WRITE && wide) |=> (words[$past(widx)] == $past(pg_data)));

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
   import uwire_pkg::*;
#(
   parameter int MEM_BITS    = 1024,
   parameter int WIDE_W      = 16,
   parameter int NARROW_W    = 8,
   parameter int PROG_CYCLES = 1250000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic org_wide,
   input  logic sk,
   input  logic cs,
   input  logic di,
   output logic dout,
   output logic dout_oe
);

   localparam int WORDS = MEM_BITS / WIDE_W;
   localparam int AW_N  = $clog2(WORDS) + 1;

   generate
      if (WIDE_W != 2 * NARROW_W) begin : g_bad_width
         $error("wide word must be two narrow words");
      end
      if (MEM_BITS % WIDE_W != 0) begin : g_bad_size
         $error("array size must be a whole number of wide words");
      end
   endgenerate

   logic              sk_s, cs_s, di_s;
   logic              sk_q, cs_q;
   logic              sk_rise, cs_fall;
   logic              busy, go, wel;
   prog_e             pg_cmd;
   logic [AW_N-1:0]   pg_addr, rd_addr;
   logic [WIDE_W-1:0] pg_data, rd_word;

   uwire_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sk, cs, di}),
      .q     ({sk_s, cs_s, di_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sk_q <= 1'b0;
         cs_q <= 1'b0;
      end else begin
         sk_q <= sk_s;
         cs_q <= cs_s;
      end
   end

   assign sk_rise = sk_s && !sk_q;
   assign cs_fall = cs_q && !cs_s;

   uwire_front #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .AW_N(AW_N)) u_front (
      .clk     (clk),
      .rst_n   (rst_n),
      .wide    (org_wide),
      .sk_rise (sk_rise),
      .cs_s    (cs_s),
      .cs_fall (cs_fall),
      .di_s    (di_s),
      .busy    (busy),
      .rd_word (rd_word),
      .rd_addr (rd_addr),
      .go      (go),
      .pg_cmd  (pg_cmd),
      .pg_addr (pg_addr),
      .pg_data (pg_data),
      .wel     (wel),
      .dout    (dout),
      .dout_oe (dout_oe)
   );

   uwire_array #(
      .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .WORDS(WORDS),
      .AW_N(AW_N), .PROG_CYCLES(PROG_CYCLES)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wide    (org_wide),
      .go      (go),
      .pg_cmd  (pg_cmd),
      .pg_addr (pg_addr),
      .pg_data (pg_data),
      .rd_addr (rd_addr),
      .rd_word (rd_word),
      .busy    (busy)
   );

   a_r9_busy_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && busy) |-> !dout);

   a_r3_launch_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));

endmodule

// File: tb/uwire_eeprom_bench.sv
module uwire_eeprom_bench;

   localparam int PROG = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic org_wide = 1'b1;
   logic sk = 1'b0;
   logic cs = 1'b0;
   logic di = 1'b0;
   logic dout, dout_oe;

   always #2 clk = ~clk;

   uwire_eeprom #(.PROG_CYCLES(PROG)) u_uwire_eeprom (
      .clk(clk), .rst_n(rst_n), .org_wide(org_wide),
      .sk(sk), .cs(cs), .di(di), .dout(dout), .dout_oe(dout_oe)
   );

   int checks = 0;
   int fails  = 0;
   logic [15:0] ref16 [64];
   logic [15:0] exp_q [$];
   logic [15:0] act_q [$];
   string       tag_q [$];
   event        got_ev;

   task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sk_bit(logic b);
      di = b; tick(4); sk = 1'b1; tick(8); sk = 1'b0; tick(4);
   endtask

   task automatic send(logic [15:0] v, int n);
      for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
   endtask

   function automatic int awid();
      return org_wide ? 6 : 7;
   endfunction

   function automatic int dwid();
      return org_wide ? 16 : 8;
   endfunction

   function automatic logic [15:0] ref_get(int a);
      if (org_wide) return ref16[a];
      if (a % 2 == 1) return {8'h00, ref16[a/2][15:8]};
      return {8'h00, ref16[a/2][7:0]};
   endfunction

   function automatic void ref_put(int a, logic [15:0] v);
      if (org_wide)       ref16[a] = v;
      else if (a % 2 == 1) ref16[a/2][15:8] = v[7:0];
      else                 ref16[a/2][7:0]  = v[7:0];
   endfunction

   function automatic void ref_fill(logic [15:0] v);
      for (int i = 0; i < 64; i++) ref16[i] = org_wide ? v : {v[7:0], v[7:0]};
   endfunction

   // driver: pushes the expectation, collects the serial word for the monitor
   task automatic rd(int a, string req, int nz = 0);
      logic [15:0] got = '0;
      exp_q.push_back(ref_get(a));
      tag_q.push_back(req);
      cs = 1'b1; tick(4);
      send(16'h0, nz);
      send(16'h1, 1); send(16'b10, 2); send(16'(a), awid());
      chk(dout_oe === 1'b1 && dout === 1'b0, "R2 dummy zero", {14'b0, dout_oe, dout}, 16'h0002);
      for (int i = 0; i < dwid(); i++) begin
         sk_bit(1'b0);
         got = {got[14:0], dout};
      end
      sk_bit(1'b0);
      chk(dout_oe === 1'b0, "R2 release after word", {15'b0, dout_oe}, 16'h0);
      cs = 1'b0; tick(6);
      act_q.push_back(got);
      -> got_ev;
   endtask

   task automatic prog(logic [1:0] op, int a, logic [15:0] d, bit has_d);
      cs = 1'b1; tick(4);
      send(16'h1, 1); send({14'b0, op}, 2); send(16'(a), awid());
      if (has_d) send(d, dwid());
      cs = 1'b0; tick(6);
   endtask

   task automatic ext(logic [1:0] e, logic [15:0] d);
      prog(2'b00, int'(e) << (awid() - 2), d, e == 2'b01);
   endtask

   task automatic settle(bit cyc, int n0, string req);
      int n = n0;
      cs = 1'b1; tick(5); n += 5;
      if (!cyc) begin
         chk(dout_oe === 1'b0, {req, " no cycle started"}, {15'b0, dout_oe}, 16'h0);
         cs = 1'b0; tick(6);
         return;
      end
      chk(dout_oe === 1'b1 && dout === 1'b0, "R9 busy level", {14'b0, dout_oe, dout}, 16'h0002);
      sk_bit(1'b1); n += 16;
      chk(dout_oe === 1'b1 && dout === 1'b0, "R9 no release while busy", {14'b0, dout_oe, dout}, 16'h0002);
      while (dout !== 1'b1 && n < PROG + 100) begin tick(1); n++; end
      chk(n >= PROG && n <= PROG + 8, "R8 busy length", 16'(n), 16'(PROG));
      chk(dout_oe === 1'b1, "R9 ready level", {15'b0, dout_oe}, 16'h1);
      sk_bit(1'b1);
      chk(dout_oe === 1'b0, "R9 release when ready", {15'b0, dout_oe}, 16'h0);
      cs = 1'b0; tick(6);
   endtask

   // monitor: compares each collected word against the queued expectation
   initial begin
      forever begin
         @(got_ev);
         while (act_q.size() > 0) begin
            logic [15:0] a_v, e_v;
            string t;
            a_v = act_q.pop_front();
            e_v = exp_q.pop_front();
            t   = tag_q.pop_front();
            chk(a_v === e_v, t, a_v, e_v);
         end
      end
   end

   initial begin
      tick(190000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      org_wide = 1'b1;
      ref_fill(16'hFFFF);
      tick(5); rst_n = 1'b1; tick(5);

      // 16-bit organization
      chk(dout_oe === 1'b0, "R10 reset output released", {15'b0, dout_oe}, 16'h0);
      rd(5, "R10 blank word");
      rd(63, "R1 top address");
      prog(2'b01, 3, 16'hA5A5, 1); settle(0, 6, "R3 locked write");
      rd(3, "R3 locked write ignored");
      ext(2'b11, 16'h0); settle(0, 6, "R3 unlock");
      prog(2'b01, 3, 16'h1234, 1); ref_put(3, 16'h1234); settle(1, 6, "R4");
      rd(3, "R4 word write");
      prog(2'b01, 3, 16'h0F0F, 1); ref_put(3, 16'h0F0F); settle(1, 6, "R4");
      rd(3, "R4 auto clear overwrite");

      // command during busy is dropped
      prog(2'b01, 10, 16'hBEEF, 1); ref_put(10, 16'hBEEF);
      cs = 1'b1; tick(5);
      send(16'h1, 1); send(16'b01, 2); send(16'd4, 6); send(16'h0000, 16);
      cs = 1'b0; tick(6);
      settle(1, 417, "R8");
      rd(4, "R8 write while busy ignored");
      rd(10, "R4 write before busy test", 3);
      rd(10, "R1 leading zeros skipped", 5);

      // truncated command
      cs = 1'b1; tick(4);
      send(16'h1, 1); send(16'b01, 2); send(16'd7, 6); send(16'h15, 5);
      cs = 1'b0; tick(6);
      settle(0, 6, "R7 cut command");
      rd(7, "R7 cut command no effect");

      prog(2'b11, 3, 16'h0, 0); ref_put(3, 16'hFFFF); settle(1, 6, "R5");
      rd(3, "R5 erase word");
      rd(10, "R5 neighbour kept");

      ext(2'b01, 16'hC3A5); ref_fill(16'hC3A5); settle(1, 6, "R6");
      for (int i = 0; i < 64; i++) rd(i, "R6 write-all");
      ext(2'b10, 16'h0); ref_fill(16'hFFFF); settle(1, 6, "R6");
      rd(0, "R6 erase-all"); rd(21, "R6 erase-all"); rd(63, "R6 erase-all");

      ext(2'b00, 16'h0); settle(0, 6, "R3 lock");
      prog(2'b01, 2, 16'h1111, 1); settle(0, 6, "R3 write after lock");
      rd(2, "R3 read while locked");

      // 8-bit organization
      rst_n = 1'b0; org_wide = 1'b0; tick(5);
      ref_fill(16'hFFFF);
      rst_n = 1'b1; tick(5);
      chk(dout_oe === 1'b0, "R10 reset output released", {15'b0, dout_oe}, 16'h0);
      prog(2'b01, 9, 16'h005A, 1); settle(0, 6, "R10 latch clear after reset");
      rd(9, "R10 byte stays blank");
      ext(2'b11, 16'h0); settle(0, 6, "R3 unlock");
      prog(2'b01, 9, 16'h005A, 1); ref_put(9, 16'h005A); settle(1, 6, "R4");
      prog(2'b01, 8, 16'h003C, 1); ref_put(8, 16'h003C); settle(1, 6, "R4");
      rd(9, "R4 odd byte"); rd(8, "R4 even byte");
      rd(127, "R1 top byte address");
      org_wide = 1'b1; tick(4);
      rd(4, "R4 byte lanes in word");
      org_wide = 1'b0; tick(4);
      prog(2'b11, 8, 16'h0, 0); ref_put(8, 16'h00FF); settle(1, 6, "R5");
      rd(8, "R5 erase byte"); rd(9, "R5 other byte kept");
      ext(2'b01, 16'h0077); ref_fill(16'h0077); settle(1, 6, "R6");
      rd(0, "R6 byte write-all"); rd(1, "R6 byte write-all");
      rd(77, "R6 byte write-all"); rd(127, "R6 byte write-all");
      ext(2'b10, 16'h0); ref_fill(16'hFFFF); settle(1, 6, "R6");
      rd(50, "R6 byte erase-all"); rd(51, "R6 byte erase-all");

      tick(20);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule